// File: doc/BRIEF.md
# Mailbox Interrupt Controller

This block raises interrupts between the two sides of a two-port shared memory of 2^AW words. It watches each side's address, select, read strobe and write strobe on a shared clock. The two top words of the memory serve as mailboxes: the all-ones address belongs to the right side, and the address one below it belongs to the left side. When one side writes the other side's mailbox word, an active-low interrupt is raised towards the owner. The interrupt drops when the owner reads its own mailbox word.

Each side also has a busy input, driven by the contention arbiter of the shared memory. While a side's busy input is high, that side's accesses neither raise the other side's interrupt nor clear its own. The message itself lives in the ordinary memory word at the mailbox address and is handled by the memory array, not by this block. Every output is registered: an access sampled on a clock edge shows on the interrupt outputs right after that edge.

Top module: `mbx_irq_ctrl`

## Requirements
- R1: A clock edge with rst_n low returns both lt_irq_n and rt_irq_n high (deasserted).
- R2: A left write (lt_sel=1, lt_wr=1, lt_busy=0) to the all-ones address drives rt_irq_n low after that edge.
- R3: A right write (rt_sel=1, rt_wr=1, rt_busy=0) to the all-ones address minus one drives lt_irq_n low after that edge.
- R4: A right read (rt_sel=1, rt_rd=1, rt_wr=0, rt_busy=0) of the all-ones address returns rt_irq_n high. A left read of the all-ones address minus one returns lt_irq_n high.
- R5: A read of the other side's mailbox word, or a write to a side's own mailbox word, changes neither interrupt.
- R6: While a side's busy input is 1, its writes raise no interrupt and its reads clear none.
- R7: When one interrupt is raised and cleared on the same edge, it ends up asserted (low).
- R8: Accesses with select at 0, accesses to any address other than the two mailboxes, and idle cycles leave both interrupts unchanged. A cycle with read and write both at 1 counts as a write only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| lt_addr | input | AW | Left word address |
| lt_sel | input | 1 | Left access select, active high |
| lt_rd | input | 1 | Left read strobe |
| lt_wr | input | 1 | Left write strobe |
| lt_busy | input | 1 | Left contention flag from the arbiter, active high |
| rt_addr | input | AW | Right word address |
| rt_sel | input | 1 | Right access select, active high |
| rt_rd | input | 1 | Right read strobe |
| rt_wr | input | 1 | Right write strobe |
| rt_busy | input | 1 | Right contention flag from the arbiter, active high |
| lt_irq_n | output | 1 | Interrupt to the left side, active low |
| rt_irq_n | output | 1 | Interrupt to the right side, active low |

## Verification
Two things can hit the same interrupt on one edge: the peer writing the owner's mailbox, and the owner reading that mailbox. The bench provokes this by driving the raising write and the clearing read on the same cycle, for both mailboxes. It also does this with busy high on one side, so that only one of the two actions is allowed through. The behavioural model in the bench says the raise wins, and the bench compares both outputs against that model on every clock. A long stretch of random traffic aimed at the two top addresses then creates many more such collisions.

// File: rtl/mbx_pkg.sv
// Package: shared types and helpers for the mailbox interrupt controller.
// Assumes address widths of at least 2 bits.
package mbx_pkg;

    // Which side of the shared memory a piece of logic serves.
    typedef enum logic {
        SIDE_LT = 1'b0,
        SIDE_RT = 1'b1
    } side_e;

    // Mailbox word owned by a side: right owns all ones, left owns all ones minus one.
    function automatic logic [31:0] mbx_box_addr(input int unsigned aw, input side_e side);
        logic [31:0] top;
        top = (32'd1 << aw) - 32'd1;
        return (side == SIDE_RT) ? top : top - 32'd1;
    endfunction

endpackage

// File: rtl/mbx_port_dec.sv
// Decoder for one side: finds a write to the peer's mailbox (post) and a read
// of the side's own mailbox (fetch). Both are blocked while the side is busy.
// Assumes read and write together mean a write.
module mbx_port_dec
    import mbx_pkg::*;
#(
    parameter int unsigned AW       = 12,
    parameter side_e       OWN_SIDE = SIDE_LT
) (
    input  logic [AW-1:0] addr_i,
    input  logic          sel_i,
    input  logic          rd_i,
    input  logic          wr_i,
    input  logic          busy_i,
    output logic          post_o,
    output logic          fetch_o
);
    localparam side_e         PEER_SIDE = (OWN_SIDE == SIDE_LT) ? SIDE_RT : SIDE_LT;
    localparam logic [31:0]   OWN_W     = mbx_box_addr(AW, OWN_SIDE);
    localparam logic [31:0]   PEER_W    = mbx_box_addr(AW, PEER_SIDE);
    localparam logic [AW-1:0] OWN_BOX   = OWN_W[AW-1:0];
    localparam logic [AW-1:0] PEER_BOX  = PEER_W[AW-1:0];

    logic live;

    // Purpose: qualify the access by select and contention.
    always_comb begin
        live = sel_i && !busy_i;
    end

    // Purpose: decode mailbox writes and reads.
    always_comb begin
        post_o  = live && wr_i && (addr_i == PEER_BOX);
        fetch_o = live && rd_i && !wr_i && (addr_i == OWN_BOX);
    end

endmodule

// File: rtl/mbx_flag.sv
// One interrupt flag: raised by set_i, dropped by clr_i, and set takes priority.
// The output is active low and registered.
module mbx_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic irq_n_o
);
    logic pend_q;

    // Purpose: hold the pending state; a raise beats a clear on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n)      pend_q <= 1'b0;
        else if (set_i)  pend_q <= 1'b1;
        else if (clr_i)  pend_q <= 1'b0;
    end

    assign irq_n_o = !pend_q;

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> !irq_n_o);
    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> irq_n_o);
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(irq_n_o));

endmodule

// File: rtl/mbx_irq_ctrl.sv
// Top: mailbox interrupts between the left and right sides of a shared memory
// of 2**AW words. It assumes that both sides share clk and that the busy
// inputs are already synchronous to it.
module mbx_irq_ctrl
    import mbx_pkg::*;
#(
    parameter int unsigned AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] lt_addr,
    input  logic          lt_sel,
    input  logic          lt_rd,
    input  logic          lt_wr,
    input  logic          lt_busy,
    input  logic [AW-1:0] rt_addr,
    input  logic          rt_sel,
    input  logic          rt_rd,
    input  logic          rt_wr,
    input  logic          rt_busy,
    output logic          lt_irq_n,
    output logic          rt_irq_n
);
    localparam int NSIDE = 2;

    logic [AW-1:0] addr_v [NSIDE];
    logic [NSIDE-1:0] sel_v, rd_v, wr_v, busy_v, post_v, fetch_v, irqn_v;

    // Purpose: gather the side ports into arrays, indexed by side.
    always_comb begin
        addr_v[0] = lt_addr;  addr_v[1] = rt_addr;
        sel_v  = {rt_sel,  lt_sel};
        rd_v   = {rt_rd,   lt_rd};
        wr_v   = {rt_wr,   lt_wr};
        busy_v = {rt_busy, lt_busy};
    end

    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        localparam side_e ME = (s == 0) ? SIDE_LT : SIDE_RT;

        mbx_port_dec #(.AW(AW), .OWN_SIDE(ME)) dec_i (
            .addr_i (addr_v[s]),
            .sel_i  (sel_v[s]),
            .rd_i   (rd_v[s]),
            .wr_i   (wr_v[s]),
            .busy_i (busy_v[s]),
            .post_o (post_v[s]),
            .fetch_o(fetch_v[s])
        );

        // A side's flag is raised by the peer's post and cleared by its own fetch.
        mbx_flag flag_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (post_v[NSIDE-1-s]),
            .clr_i  (fetch_v[s]),
            .irq_n_o(irqn_v[s])
        );
    end

    assign lt_irq_n = irqn_v[0];
    assign rt_irq_n = irqn_v[1];

    assert_busy_no_post_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lt_busy && !rt_irq_n == 1'b0 && !post_v[1] == 1'b1 && !fetch_v[1]) |=> rt_irq_n);
    assert_busy_no_fetch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rt_busy && !rt_irq_n && !post_v[0]) |=> !rt_irq_n);

endmodule

// File: tb/mbx_irq_ctrl_tb.sv
// Bench: behavioural reference model, compared against both outputs on every clock.
module mbx_irq_ctrl_tb_top;
    localparam int AW = 12;
    localparam logic [AW-1:0] TOP  = {AW{1'b1}};
    localparam logic [AW-1:0] TOP1 = TOP - 1'b1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] lt_addr = '0, rt_addr = '0;
    logic lt_sel = 0, lt_rd = 0, lt_wr = 0, lt_busy = 0;
    logic rt_sel = 0, rt_rd = 0, rt_wr = 0, rt_busy = 0;
    logic lt_irq_n, rt_irq_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    bit exp_lt = 0;   // 1 = left interrupt pending (lt_irq_n low)
    bit exp_rt = 0;
    string last_tag = "R1";

    always #5 clk = ~clk;

    mbx_irq_ctrl #(.AW(AW)) dut_i (.*);

    task automatic check_out();
        checks += 2;
        if (lt_irq_n !== !exp_lt) begin
            fails++;
            $display("FAIL %s lt_irq_n actual=%b expected=%b", last_tag, lt_irq_n, !exp_lt);
        end
        if (rt_irq_n !== !exp_rt) begin
            fails++;
            $display("FAIL %s rt_irq_n actual=%b expected=%b", last_tag, rt_irq_n, !exp_rt);
        end
    endtask

    // One cycle: compare the outputs left by the previous cycle, then drive the
    // next access and advance the model to what that edge should produce.
    task automatic cyc(input logic rn,
                       input logic [AW-1:0] la, input logic ls, input logic lr, input logic lw, input logic lb,
                       input logic [AW-1:0] ra, input logic rs, input logic rr, input logic rw, input logic rb,
                       input string tag);
        bit lpost, lfetch, rpost, rfetch;
        @(negedge clk);
        check_out();
        rst_n = rn;
        lt_addr = la; lt_sel = ls; lt_rd = lr; lt_wr = lw; lt_busy = lb;
        rt_addr = ra; rt_sel = rs; rt_rd = rr; rt_wr = rw; rt_busy = rb;
        last_tag = tag;
        lpost  = ls && !lb && lw && la == TOP;
        lfetch = ls && !lb && lr && !lw && la == TOP1;
        rpost  = rs && !rb && rw && ra == TOP1;
        rfetch = rs && !rb && rr && !rw && ra == TOP;
        if (!rn) begin
            exp_lt = 0; exp_rt = 0;
        end else begin
            if (rpost) exp_lt = 1; else if (lfetch) exp_lt = 0;
            if (lpost) exp_rt = 1; else if (rfetch) exp_rt = 0;
        end
    endtask

    task automatic idle(input string tag);
        cyc(1, '0, 0, 0, 0, 0, '0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset
        cyc(0, '0, 0, 0, 0, 0, '0, 0, 0, 0, 0, "R1");
        cyc(0, '0, 0, 0, 0, 0, '0, 0, 0, 0, 0, "R1");
        idle("R1");
        // R2: left posts to right mailbox
        cyc(1, TOP, 1, 0, 1, 0, '0, 0, 0, 0, 0, "R2");
        idle("R2");
        // R5: left reads right mailbox (no clear), right reads left mailbox
        cyc(1, TOP, 1, 1, 0, 0, TOP1, 1, 1, 0, 0, "R5");
        // R4: right fetches its mailbox
        cyc(1, '0, 0, 0, 0, 0, TOP, 1, 1, 0, 0, "R4");
        idle("R4");
        // R3: right posts to left mailbox
        cyc(1, '0, 0, 0, 0, 0, TOP1, 1, 0, 1, 0, "R3");
        idle("R3");
        // R5: own-mailbox writes set nothing
        cyc(1, TOP1, 1, 0, 1, 0, TOP, 1, 0, 1, 0, "R5");
        idle("R5");
        // R8: deselected reads, other addresses, read+write as write
        cyc(1, TOP1, 0, 1, 0, 0, TOP, 0, 0, 1, 0, "R8");
        cyc(1, TOP - 2, 1, 1, 0, 0, 12'h000, 1, 0, 1, 0, "R8");
        cyc(1, TOP1, 1, 1, 1, 0, '0, 0, 0, 0, 0, "R8");
        idle("R8");
        // R4: left fetch clears left
        cyc(1, TOP1, 1, 1, 0, 0, '0, 0, 0, 0, 0, "R4");
        idle("R4");
        // R6: busy blocks post and fetch
        cyc(1, TOP, 1, 0, 1, 1, TOP1, 1, 0, 1, 1, "R6");
        idle("R6");
        cyc(1, TOP, 1, 0, 1, 0, '0, 0, 0, 0, 0, "R6");
        cyc(1, '0, 0, 0, 0, 0, TOP, 1, 1, 0, 1, "R6");
        idle("R6");
        // R7: raise and clear of the right flag on the same edge
        cyc(1, TOP, 1, 0, 1, 0, TOP, 1, 1, 0, 0, "R7");
        idle("R7");
        // R7: same for the left flag, from a clear state
        cyc(1, TOP1, 1, 1, 0, 0, TOP1, 1, 0, 1, 0, "R7");
        idle("R7");
        // R6 with R7: busy right lets only the clear through
        cyc(1, TOP1, 1, 1, 0, 0, TOP1, 1, 0, 1, 1, "R6");
        idle("R6");
        // R1: reset while pending
        cyc(0, '0, 0, 0, 0, 0, '0, 0, 0, 0, 0, "R1");
        idle("R1");
        // Random traffic near the mailboxes
        for (int i = 0; i < 600; i++) begin
            logic [AW-1:0] la, ra;
            int k;
            k = $urandom % 4; la = (k == 0) ? TOP : (k == 1) ? TOP1 : (k == 2) ? TOP - 2 : AW'($urandom);
            k = $urandom % 4; ra = (k == 0) ? TOP : (k == 1) ? TOP1 : (k == 2) ? TOP - 2 : AW'($urandom);
            cyc(1, la, 1'($urandom), 1'($urandom), 1'($urandom), ($urandom % 4) == 0,
                   ra, 1'($urandom), 1'($urandom), 1'($urandom), ($urandom % 4) == 0, "R8");
        end
        idle("R8");
        @(negedge clk);
        check_out();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule